// File: doc/BRIEF.md
# Daisy-Chained Interrupt Priority Controller

This block arbitrates interrupt requests from the six internal source groups of one serial channel and joins the channel to an external priority daisy chain. Three of the groups are status groups. Each of them merges several condition inputs, and every condition has its own enable bit. The other three groups each take a single request line. For each group the block keeps a pending flag and an under-service flag.

When an interrupt acknowledge strobe arrives, the block selects the highest-priority eligible group. It reports a 3-bit code for that group in the same cycle and marks the group as under service. Any flag that is under service holds off the same group and every lower group inside the channel. It also pulls the chain output low, so devices further down the chain cannot request. A "clear top service" command releases the highest-priority group that is under service, which re-opens the next level down.

Top module: `irq_daisy_arbiter`

## Requirements
- R1: Groups have a fixed priority and code, from highest to lowest: receive status = 0, receive data = 1, transmit status = 2, transmit data = 3, I/O status = 4, device status = 5. When several groups are eligible, the lowest code wins.
- R2: Each status group ORs its conditions. Condition bit i counts only when enable bit i is 1. The receive status and transmit status groups have 6 conditions each. The device status group has 4.
- R3: A group's pending flag follows its merged request one clock later and stays set for as long as the request is held. A group can request only when its bit in `grpEn` is 1 (bit index = group code).
- R4: While `intAck` is high and at least one group is eligible, `vecValid` is 1 and `vecCode` shows the winner's code. The winner's under-service flag is set at that clock edge. With no eligible group, `vecValid` is 0 and nothing is set.
- R5: A set under-service flag stops its own group and every lower-priority group from requesting. Higher-priority groups can still request.
- R6: `ieo` is 0 while any under-service flag is set.
- R7: `ieo` equals `iei` AND no flag under service AND NOT (`intAck` high with an eligible group).
- R8: When `iei` is 0, `intReq` and `vecValid` are 0, `ieo` is 0, and an acknowledge sets no flag.
- R9: A `clrTopIus` pulse clears only the highest-priority under-service flag that is set. Any flags below it stay set.
- R10: After reset all flags are clear, `intReq` and `vecValid` are 0, and `ieo` follows `iei`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxStatCond | input | 6 | Receive status conditions |
| rxStatEn | input | 6 | Receive status condition enables |
| rxDataReq | input | 1 | Receive data request |
| txStatCond | input | 6 | Transmit status conditions |
| txStatEn | input | 6 | Transmit status condition enables |
| txDataReq | input | 1 | Transmit data request |
| ioStatReq | input | 1 | I/O status request |
| devStatCond | input | 4 | Device status conditions |
| devStatEn | input | 4 | Device status condition enables |
| grpEn | input | 6 | Per-group request enable, bit = group code |
| iei | input | 1 | Chain enable from higher-priority devices |
| intAck | input | 1 | Interrupt acknowledge strobe |
| clrTopIus | input | 1 | Clear highest set under-service flag |
| intReq | output | 1 | Interrupt request |
| ieo | output | 1 | Chain enable to lower-priority devices |
| vecValid | output | 1 | Code valid during acknowledge |
| vecCode | output | 3 | Serviced group code |

## Verification
The bench checks nested service. A lower group is acknowledged first, then a higher group preempts it. A design that cleared every flag on one command, or the lowest flag instead of the highest, would let the blocked lower group request too early, or would keep it blocked too long. The bench also checks a low `iei`, which must silence an acknowledge: a design that ignored it would capture a flag. Condition bits whose enable is off must not request; getting that wrong makes the receive status group win an arbitration that belongs to a lower group. Finally, the bench checks that `ieo` drops in the acknowledge cycle itself and not one cycle later.

// File: rtl/irq_daisy_pkg.sv
package irq_daisy_pkg;
  localparam int NUM_GRP = 6;
  localparam int CODE_W  = 3;
  localparam int RS_W    = 6;
  localparam int TS_W    = 6;
  localparam int DS_W    = 4;

  typedef logic [NUM_GRP-1:0] grpMask_t;

  typedef enum logic [CODE_W-1:0] {
    GRP_RX_STAT = 3'd0,
    GRP_RX_DATA = 3'd1,
    GRP_TX_STAT = 3'd2,
    GRP_TX_DATA = 3'd3,
    GRP_IO_STAT = 3'd4,
    GRP_DEV_STAT = 3'd5
  } grpCode_e;

  // strobes from control to datapath
  typedef struct packed {
    grpMask_t setMask;
    grpMask_t clrMask;
  } iusStrobe_t;
endpackage

// File: rtl/irq_daisy_dp.sv
module irq_daisy_dp
  import irq_daisy_pkg::*;
#(
  parameter int RsW = RS_W,
  parameter int TsW = TS_W,
  parameter int DsW = DS_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [RsW-1:0] rxStatCond,
  input  logic [RsW-1:0] rxStatEn,
  input  logic           rxDataReq,
  input  logic [TsW-1:0] txStatCond,
  input  logic [TsW-1:0] txStatEn,
  input  logic           txDataReq,
  input  logic           ioStatReq,
  input  logic [DsW-1:0] devStatCond,
  input  logic [DsW-1:0] devStatEn,
  input  iusStrobe_t     strobe,
  output grpMask_t       ipFlag,
  output grpMask_t       iusFlag
);
  grpMask_t rawReq;
  grpMask_t ipQ;
  grpMask_t iusQ;

  // merged per-group request, bit index = group code
  always_comb begin
    rawReq = '0;
    rawReq[GRP_RX_STAT]  = |(rxStatCond & rxStatEn);
    rawReq[GRP_RX_DATA]  = rxDataReq;
    rawReq[GRP_TX_STAT]  = |(txStatCond & txStatEn);
    rawReq[GRP_TX_DATA]  = txDataReq;
    rawReq[GRP_IO_STAT]  = ioStatReq;
    rawReq[GRP_DEV_STAT] = |(devStatCond & devStatEn);
  end

  always_ff @(posedge clk) begin
    if (!rstN) ipQ <= '0;
    else       ipQ <= rawReq;
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_ius
    always_ff @(posedge clk) begin
      if (!rstN) iusQ[g] <= 1'b0;
      else       iusQ[g] <= (iusQ[g] & ~strobe.clrMask[g]) | strobe.setMask[g];
    end
  end

  assign ipFlag  = ipQ;
  assign iusFlag = iusQ;

  // a flag under service only appears where control asked for it (R4)
  assert_ius_rise_from_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((iusQ & ~$past(iusQ) & ~$past(strobe.setMask)) == '0));

  // a lone clear command drops exactly one flag (R9)
  assert_clr_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrMask != '0 && strobe.setMask == '0)
      |=> $countones(iusQ) == $countones($past(iusQ)) - 1);

  assert_set_clr_disjoint_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.setMask & strobe.clrMask) == '0);
endmodule

// File: rtl/irq_daisy_ctl.sv
module irq_daisy_ctl
  import irq_daisy_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  grpMask_t          ipFlag,
  input  grpMask_t          iusFlag,
  input  grpMask_t          grpEn,
  input  logic              iei,
  input  logic              intAck,
  input  logic              clrTopIus,
  output iusStrobe_t        strobe,
  output logic              intReq,
  output logic              ieo,
  output logic              vecValid,
  output logic [CODE_W-1:0] vecCode
);
  grpMask_t blockMask;
  grpMask_t elig;
  grpMask_t winMask;
  grpMask_t iusTop;
  logic [CODE_W-1:0] winIdx;
  logic anyElig;
  logic anyIus;

  // a flag at level g blocks g and all lower levels
  assign blockMask[0] = iusFlag[0];
  for (genvar g = 1; g < NUM_GRP; g++) begin : g_block
    assign blockMask[g] = blockMask[g-1] | iusFlag[g];
  end

  assign elig    = ipFlag & grpEn & ~blockMask & {NUM_GRP{iei}};
  assign anyElig = |elig;
  assign anyIus  = |iusFlag;

  // isolate lowest set bit = highest priority
  assign winMask = elig & (~elig + grpMask_t'(1));
  assign iusTop  = iusFlag & (~iusFlag + grpMask_t'(1));

  always_comb begin
    winIdx = '0;
    for (int g = NUM_GRP - 1; g >= 0; g--)
      if (elig[g]) winIdx = CODE_W'(g);
  end

  assign strobe.setMask = intAck ? winMask : '0;
  assign strobe.clrMask = clrTopIus ? iusTop : '0;

  assign intReq   = anyElig;
  assign vecValid = intAck & anyElig;
  assign vecCode  = vecValid ? winIdx : '0;
  assign ieo      = iei & ~anyIus & ~(intAck & anyElig);

  assert_ieo_low_service_R6: assert property (@(posedge clk) disable iff (!rstN)
    anyIus |-> !ieo);

  assert_chain_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    !iei |-> (!intReq && !vecValid && !ieo));

  assert_code_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> (vecCode < CODE_W'(NUM_GRP)));

  assert_single_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.setMask));
endmodule

// File: rtl/irq_daisy_arbiter.sv
module irq_daisy_arbiter
  import irq_daisy_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [RS_W-1:0]   rxStatCond,
  input  logic [RS_W-1:0]   rxStatEn,
  input  logic              rxDataReq,
  input  logic [TS_W-1:0]   txStatCond,
  input  logic [TS_W-1:0]   txStatEn,
  input  logic              txDataReq,
  input  logic              ioStatReq,
  input  logic [DS_W-1:0]   devStatCond,
  input  logic [DS_W-1:0]   devStatEn,
  input  logic [NUM_GRP-1:0] grpEn,
  input  logic              iei,
  input  logic              intAck,
  input  logic              clrTopIus,
  output logic              intReq,
  output logic              ieo,
  output logic              vecValid,
  output logic [CODE_W-1:0] vecCode
);
  iusStrobe_t strobe;
  grpMask_t   ipFlag;
  grpMask_t   iusFlag;

  irq_daisy_dp #(.RsW(RS_W), .TsW(TS_W), .DsW(DS_W)) dp_i (
    .clk(clk), .rstN(rstN),
    .rxStatCond(rxStatCond), .rxStatEn(rxStatEn), .rxDataReq(rxDataReq),
    .txStatCond(txStatCond), .txStatEn(txStatEn), .txDataReq(txDataReq),
    .ioStatReq(ioStatReq), .devStatCond(devStatCond), .devStatEn(devStatEn),
    .strobe(strobe), .ipFlag(ipFlag), .iusFlag(iusFlag)
  );

  irq_daisy_ctl ctl_i (
    .clk(clk), .rstN(rstN),
    .ipFlag(ipFlag), .iusFlag(iusFlag), .grpEn(grpEn),
    .iei(iei), .intAck(intAck), .clrTopIus(clrTopIus),
    .strobe(strobe), .intReq(intReq), .ieo(ieo),
    .vecValid(vecValid), .vecCode(vecCode)
  );
endmodule

// File: tb/irq_daisy_arbiter_tb.sv
`timescale 1ns/1ps
module irq_daisy_arbiter_tb_top;
  logic clk = 1'b0;
  logic rstN;
  logic [5:0] rxStatCond, rxStatEn, txStatCond, txStatEn, grpEn;
  logic rxDataReq, txDataReq, ioStatReq, iei, intAck, clrTopIus;
  logic [3:0] devStatCond, devStatEn;
  logic intReq, ieo, vecValid;
  logic [2:0] vecCode;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  irq_daisy_arbiter dut_i (
    .clk(clk), .rstN(rstN),
    .rxStatCond(rxStatCond), .rxStatEn(rxStatEn), .rxDataReq(rxDataReq),
    .txStatCond(txStatCond), .txStatEn(txStatEn), .txDataReq(txDataReq),
    .ioStatReq(ioStatReq), .devStatCond(devStatCond), .devStatEn(devStatEn),
    .grpEn(grpEn), .iei(iei), .intAck(intAck), .clrTopIus(clrTopIus),
    .intReq(intReq), .ieo(ieo), .vecValid(vecValid), .vecCode(vecCode)
  );

  typedef struct packed {
    logic [5:0] rsC; logic [5:0] rsE; logic rd;
    logic [5:0] tsC; logic [5:0] tsE; logic td; logic io;
    logic [3:0] dsC; logic [3:0] dsE; logic [5:0] gEn;
    logic expReq; logic [2:0] expCode;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{6'b000100, 6'b000100, 1'b0, 6'b0, 6'b0, 1'b0, 1'b0, 4'b0, 4'b0, 6'h3F, 1'b1, 3'd0},
    '{6'b000100, 6'b001000, 1'b0, 6'b0, 6'b0, 1'b1, 1'b0, 4'b0, 4'b0, 6'h3F, 1'b1, 3'd3},
    '{6'b0, 6'b0, 1'b1, 6'b0, 6'b0, 1'b0, 1'b1, 4'b0, 4'b0, 6'h3F, 1'b1, 3'd1},
    '{6'b0, 6'b0, 1'b0, 6'b100000, 6'b100000, 1'b0, 1'b1, 4'b0, 4'b0, 6'h3F, 1'b1, 3'd2},
    '{6'b0, 6'b0, 1'b0, 6'b0, 6'b0, 1'b0, 1'b0, 4'b0001, 4'b0001, 6'h3F, 1'b1, 3'd5},
    '{6'b0, 6'b0, 1'b0, 6'b0, 6'b0, 1'b0, 1'b0, 4'b1000, 4'b0111, 6'h3F, 1'b0, 3'd0},
    '{6'b0, 6'b0, 1'b1, 6'b0, 6'b0, 1'b0, 1'b1, 4'b0, 4'b0, 6'h3D, 1'b1, 3'd4},
    '{6'b0, 6'b0, 1'b0, 6'b0, 6'b0, 1'b0, 1'b0, 4'b0, 4'b0, 6'h3F, 1'b0, 3'd0},
    '{6'b111111, 6'b111111, 1'b0, 6'b0, 6'b0, 1'b0, 1'b0, 4'b1111, 4'b1111, 6'h00, 1'b0, 3'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic clearSrc();
    rxStatCond = '0; rxStatEn = '0; rxDataReq = 0;
    txStatCond = '0; txStatEn = '0; txDataReq = 0; ioStatReq = 0;
    devStatCond = '0; devStatEn = '0;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clearSrc();
    grpEn = 6'h3F; iei = 1; intAck = 0; clrTopIus = 0; rstN = 0;
    repeat (3) step();
    rstN = 1;
    step();
    // R10 reset state
    chk("R10 intReq", intReq, 0);
    chk("R10 ieo", ieo, 1);
    chk("R10 vecValid", vecValid, 0);

    // vector table: R1 priority, R2 merging, R3 group enable, R4/R7 ack
    for (int i = 0; i < NVEC; i++) begin
      rxStatCond = VECS[i].rsC; rxStatEn = VECS[i].rsE; rxDataReq = VECS[i].rd;
      txStatCond = VECS[i].tsC; txStatEn = VECS[i].tsE; txDataReq = VECS[i].td;
      ioStatReq = VECS[i].io; devStatCond = VECS[i].dsC; devStatEn = VECS[i].dsE;
      grpEn = VECS[i].gEn;
      step();
      chk($sformatf("R2 R3 vec%0d intReq", i), intReq, VECS[i].expReq);
      intAck = 1; #1;
      chk($sformatf("R4 vec%0d vecValid", i), vecValid, VECS[i].expReq);
      if (VECS[i].expReq) chk($sformatf("R1 vec%0d vecCode", i), vecCode, VECS[i].expCode);
      chk($sformatf("R7 vec%0d ieo during ack", i), ieo, !VECS[i].expReq);
      step();
      intAck = 0; #1;
      if (VECS[i].expReq) begin
        chk($sformatf("R6 vec%0d ieo after ack", i), ieo, 0);
        clrTopIus = 1; step(); clrTopIus = 0;
      end
      clearSrc(); grpEn = 6'h3F;
      step();
    end

    // R8: low iei silences the channel
    iei = 0; rxDataReq = 1;
    step();
    chk("R8 intReq iei low", intReq, 0);
    chk("R8 ieo iei low", ieo, 0);
    intAck = 1; #1;
    chk("R8 vecValid iei low", vecValid, 0);
    step();
    intAck = 0; iei = 1; #1;
    chk("R8 no flag captured", intReq, 1);
    chk("R8 ieo restored", ieo, 1);

    // R5 / R9 nested service: receive data acknowledged first
    intAck = 1; step(); intAck = 0; #1;
    chk("R5 own group blocked", intReq, 0);
    chk("R6 ieo low", ieo, 0);
    ioStatReq = 1; step();
    chk("R5 lower group blocked", intReq, 0);
    rxStatCond = 6'b000001; rxStatEn = 6'b000001; step();
    chk("R5 higher group passes", intReq, 1);
    intAck = 1; #1;
    chk("R1 nested code", vecCode, 0);
    step(); intAck = 0; #1;
    chk("R5 all blocked", intReq, 0);
    clrTopIus = 1; step(); clrTopIus = 0;
    rxStatCond = '0; step();
    chk("R9 lower flag kept", intReq, 0);
    chk("R9 ieo still low", ieo, 0);
    clrTopIus = 1; step(); clrTopIus = 0; #1;
    chk("R9 second clear", intReq, 1);
    chk("R7 ieo high idle", ieo, 1);
    intAck = 1; #1;
    chk("R1 reopened code", vecCode, 1);
    intAck = 0;
    // R3 pending held while source held, dropped after release
    rxDataReq = 0; ioStatReq = 0; step();
    chk("R3 pending drops", intReq, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule